// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the sixteen 32-bit general registers that a processor core with seven operating modes presents to its instructions. Every access names a 4-bit register number. The 5-bit current mode then picks which physical copy that number reaches. Low registers are common to every mode. The stack pointer (R13) and the link register (R14) have a private copy in each exception mode. The fast-interrupt mode also keeps private copies of R8 through R12. System mode reaches the same copies as user mode. R15 is not stored: a read of R15 returns the program counter that the core supplies.

Two combinational read ports and one clocked write port serve the datapath. A second write path, which a parameter can remove, lets an exception sequencer load the link register of any target mode, whatever mode is current. A small side store keeps one saved status word for each exception mode. The current mode selects the slot for reads and writes.

Top module: `banked_regfile`

## Requirements
- R1: After reset every stored register, in every mode, reads as zero, and every saved status slot reads as zero.
- R2: Register numbers 0 to 7 reach one physical copy that all modes share.
- R3: Register numbers 8 to 12 reach a private copy in fast-interrupt mode (mode 10001). Every other mode reaches the user copy.
- R4: Register numbers 13 and 14 reach a private copy in each of the five exception modes (FIQ 10001, IRQ 10010, supervisor 10011, abort 10111, undefined 11011). User mode (10000) and system mode (11111) reach the same user copy.
- R5: A mode code outside the seven listed codes selects the user copies for both reads and writes.
- R6: A read of register number 15 returns `pc_value` on either port. A write to register number 15 changes no stored register.
- R7: A write lands on the clock edge. A read of the target register in the same cycle returns the old value, and the new value is visible in the next cycle.
- R8: The two read ports address the registers independently, and both ports can read in the same cycle.
- R9: When `lr_ovr_en` is high, the R14 copy selected by `lr_ovr_mode` is loaded with `lr_ovr_data` at the clock edge, whatever the current mode is. If a normal write hits the same physical register in the same cycle, the override value is the one stored.
- R10: Each exception mode has its own saved status slot. `spsr_wr_en` writes the slot of the current mode, and `spsr_rd_data` shows the slot of the current mode.
- R11: In user, system or an unlisted mode, `spsr_rd_data` reads zero and a saved status write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 5 | Current operating mode code |
| rd_a_idx | input | 4 | Register number for read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Register number for read port B |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable for the normal write port |
| wr_idx | input | 4 | Register number for the normal write |
| wr_data | input | 32 | Normal write data |
| pc_value | input | 32 | Program counter value returned for R15 |
| lr_ovr_en | input | 1 | Enable for the link register override |
| lr_ovr_mode | input | 5 | Mode whose R14 copy the override loads |
| lr_ovr_data | input | 32 | Override data |
| spsr_wr_en | input | 1 | Saved status write enable, current mode |
| spsr_wr_data | input | 32 | Saved status write data |
| spsr_rd_data | output | 32 | Saved status word of the current mode |

## Verification
The normal write port and the link register override can both hit one physical R14 in the same cycle. The bench provokes this in user mode with a normal write to register 14 and an override that targets system mode, which shares the user copy. It expects the override data to be read back through both the user and the system view. A second collision sits inside one cycle: a read and a write of the same register. The bench judges it by sampling the old value before the edge and the new value after it. The override is also exercised across modes, targeting a mode that is not current, and the bench then confirms that the current mode's copy did not change.

// File: rtl/banked_rf_pkg.sv
package banked_rf_pkg;

   typedef enum logic [4:0] {
      MODE_USR = 5'b10000,
      MODE_FIQ = 5'b10001,
      MODE_IRQ = 5'b10010,
      MODE_SVC = 5'b10011,
      MODE_ABT = 5'b10111,
      MODE_UND = 5'b11011,
      MODE_SYS = 5'b11111
   } mode_e;

   // bank 0 = user/system, 1 = fast interrupt, 2..5 = other exception modes
   localparam int NUM_BANKS  = 6;
   localparam int BANK_W     = 3;
   localparam int FIQ_BANK   = 1;
   localparam int LO_REGS    = 8;
   localparam int FIQ_PRIV   = 5;
   localparam int SL_BASE    = LO_REGS + 2 * FIQ_PRIV;
   localparam int PHYS_REGS  = SL_BASE + 2 * NUM_BANKS;
   localparam int PHYS_W     = $clog2(PHYS_REGS);
   localparam int STAT_SLOTS = NUM_BANKS - 1;
   localparam logic [3:0] PC_IDX = 4'd15;

   function automatic logic [BANK_W-1:0] bank_of(input logic [4:0] m);
      case (m)
         MODE_FIQ: return BANK_W'(1);
         MODE_IRQ: return BANK_W'(2);
         MODE_SVC: return BANK_W'(3);
         MODE_ABT: return BANK_W'(4);
         MODE_UND: return BANK_W'(5);
         default:  return BANK_W'(0);
      endcase
   endfunction

   function automatic logic [PHYS_W-1:0] phys_of(input logic [BANK_W-1:0] b,
                                                 input logic [3:0] r);
      int ri;
      int bi;
      ri = int'(r);
      bi = int'(b);
      if (ri < LO_REGS)
         return PHYS_W'(ri);
      else if (ri < LO_REGS + FIQ_PRIV)
         return (bi == FIQ_BANK) ? PHYS_W'(ri + FIQ_PRIV) : PHYS_W'(ri);
      else if (ri < 15)
         return PHYS_W'(SL_BASE + 2 * bi + (ri - (LO_REGS + FIQ_PRIV)));
      else
         return PHYS_W'(0);
   endfunction

endpackage

// File: rtl/rf_bank_map.sv
module rf_bank_map
   import banked_rf_pkg::*;
(
   input  logic [4:0]        mode,
   input  logic [3:0]        idx,
   output logic [PHYS_W-1:0] phys,
   output logic              stored
);
   logic [BANK_W-1:0] bank;

   always_comb begin
      bank   = bank_of(mode);
      phys   = phys_of(bank, idx);
      stored = (idx != PC_IDX);
   end
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 30,
   parameter int NRD    = 2,
   parameter int AW     = $clog2(DEPTH)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [AW-1:0]              wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic                       ovr_en,
   input  logic [AW-1:0]              ovr_addr,
   input  logic [DATA_W-1:0]          ovr_data,
   input  logic [NRD-1:0][AW-1:0]     rd_addr,
   output logic [NRD-1:0][DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] mem [DEPTH];

   // the override is assigned last, so it wins a same-entry collision
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         if (wr_en)  mem[wr_addr]  <= wr_data;
         if (ovr_en) mem[ovr_addr] <= ovr_data;
      end
   end

   for (genvar k = 0; k < NRD; k++) begin : g_rd
      assign rd_data[k] = mem[rd_addr[k]];
   end
endmodule

// File: rtl/rf_status_bank.sv
module rf_status_bank
   import banked_rf_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int SLOTS  = STAT_SLOTS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [4:0]        mode,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] slot_q [SLOTS];
   logic [BANK_W-1:0] bank;
   logic              has_slot;
   logic [BANK_W-1:0] sel;

   always_comb begin
      bank     = bank_of(mode);
      has_slot = (bank != '0);
      sel      = has_slot ? bank - BANK_W'(1) : '0;
      rd_data  = has_slot ? slot_q[sel] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SLOTS; i++) slot_q[i] <= '0;
      end else if (wr_en && has_slot) begin
         slot_q[sel] <= wr_data;
      end
   end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
   import banked_rf_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter bit LR_OVR_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [4:0]        mode,
   input  logic [3:0]        rd_a_idx,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [3:0]        rd_b_idx,
   output logic [DATA_W-1:0] rd_b_data,
   input  logic              wr_en,
   input  logic [3:0]        wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] pc_value,
   input  logic              lr_ovr_en,
   input  logic [4:0]        lr_ovr_mode,
   input  logic [DATA_W-1:0] lr_ovr_data,
   input  logic              spsr_wr_en,
   input  logic [DATA_W-1:0] spsr_wr_data,
   output logic [DATA_W-1:0] spsr_rd_data
);
   localparam int NRD = 2;

   if (DATA_W < 8) begin : g_bad_width
      $error("banked_regfile: DATA_W must be at least 8");
   end
   if (PHYS_REGS > (1 << PHYS_W)) begin : g_bad_depth
      $error("banked_regfile: physical index too narrow");
   end

   logic [NRD-1:0][3:0]        rd_idx;
   logic [NRD-1:0][PHYS_W-1:0] rd_phys;
   logic [NRD-1:0]             rd_stored;
   logic [NRD-1:0][DATA_W-1:0] rd_raw;
   logic [NRD-1:0][DATA_W-1:0] rd_out;

   assign rd_idx[0] = rd_a_idx;
   assign rd_idx[1] = rd_b_idx;

   for (genvar k = 0; k < NRD; k++) begin : g_rport
      rf_bank_map u_map (
         .mode   (mode),
         .idx    (rd_idx[k]),
         .phys   (rd_phys[k]),
         .stored (rd_stored[k])
      );
      assign rd_out[k] = rd_stored[k] ? rd_raw[k] : pc_value;
   end

   assign rd_a_data = rd_out[0];
   assign rd_b_data = rd_out[1];

   logic [PHYS_W-1:0] wr_phys;
   logic              wr_stored;

   rf_bank_map u_wmap (
      .mode   (mode),
      .idx    (wr_idx),
      .phys   (wr_phys),
      .stored (wr_stored)
   );

   logic [PHYS_W-1:0] ovr_phys;
   logic              ovr_go;

   if (LR_OVR_EN) begin : g_ovr
      logic ovr_stored;
      rf_bank_map u_omap (
         .mode   (lr_ovr_mode),
         .idx    (4'd14),
         .phys   (ovr_phys),
         .stored (ovr_stored)
      );
      assign ovr_go = lr_ovr_en && ovr_stored;
   end else begin : g_no_ovr
      assign ovr_phys = '0;
      assign ovr_go   = 1'b0;
   end

   rf_storage #(
      .DATA_W (DATA_W),
      .DEPTH  (PHYS_REGS),
      .NRD    (NRD),
      .AW     (PHYS_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en && wr_stored),
      .wr_addr  (wr_phys),
      .wr_data  (wr_data),
      .ovr_en   (ovr_go),
      .ovr_addr (ovr_phys),
      .ovr_data (lr_ovr_data),
      .rd_addr  (rd_phys),
      .rd_data  (rd_raw)
   );

   rf_status_bank #(
      .DATA_W (DATA_W),
      .SLOTS  (STAT_SLOTS)
   ) u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode),
      .wr_en   (spsr_wr_en),
      .wr_data (spsr_wr_data),
      .rd_data (spsr_rd_data)
   );
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk
   import banked_rf_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter bit LR_OVR_EN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [4:0]        mode,
   input logic [3:0]        rd_a_idx,
   input logic [DATA_W-1:0] rd_a_data,
   input logic [3:0]        rd_b_idx,
   input logic [DATA_W-1:0] rd_b_data,
   input logic              wr_en,
   input logic [3:0]        wr_idx,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] pc_value,
   input logic              lr_ovr_en,
   input logic [4:0]        lr_ovr_mode,
   input logic [DATA_W-1:0] lr_ovr_data,
   input logic              spsr_wr_en,
   input logic [DATA_W-1:0] spsr_wr_data,
   input logic [DATA_W-1:0] spsr_rd_data
);
   logic started;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) started <= 1'b0;
      else        started <= 1'b1;
   end

   AST_PC_READ_A: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_a_idx == 4'd15) |-> (rd_a_data == pc_value)); // R6

   AST_PC_READ_B: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_b_idx == 4'd15) |-> (rd_b_data == pc_value)); // R6

   AST_NO_USER_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_of(mode) == '0) |-> (spsr_rd_data == '0)); // R11

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (started && $past(wr_en) && !$past(lr_ovr_en) && ($past(wr_idx) != 4'd15)
       && ($past(wr_idx) == rd_a_idx) && (mode == $past(mode)))
      |-> (rd_a_data == $past(wr_data))); // R7

   AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (started && !$past(wr_en) && !$past(lr_ovr_en) && $stable(mode)
       && $stable(rd_b_idx) && (rd_b_idx != 4'd15))
      |-> $stable(rd_b_data)); // R8

   AST_LR_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (LR_OVR_EN && started && $past(lr_ovr_en) && (rd_b_idx == 4'd14)
       && (bank_of(mode) == bank_of($past(lr_ovr_mode))))
      |-> (rd_b_data == $past(lr_ovr_data))); // R9

   AST_STATUS_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (started && $past(spsr_wr_en) && (bank_of($past(mode)) != '0)
       && (mode == $past(mode)))
      |-> (spsr_rd_data == $past(spsr_wr_data))); // R10
endmodule

bind banked_regfile banked_regfile_chk #(
   .DATA_W    (DATA_W),
   .LR_OVR_EN (LR_OVR_EN)
) u_chk (.*);

// File: tb/sim_banked_regfile.sv
`timescale 1ns/1ps
module sim_banked_regfile;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [4:0]  mode;
   logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
   logic [31:0] rd_a_data, rd_b_data, wr_data, pc_value;
   logic        wr_en, lr_ovr_en, spsr_wr_en;
   logic [4:0]  lr_ovr_mode;
   logic [31:0] lr_ovr_data, spsr_wr_data, spsr_rd_data;

   int n_chk = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   banked_regfile u0 (
      .clk(clk), .rst_n(rst_n), .mode(mode),
      .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
      .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .pc_value(pc_value),
      .lr_ovr_en(lr_ovr_en), .lr_ovr_mode(lr_ovr_mode), .lr_ovr_data(lr_ovr_data),
      .spsr_wr_en(spsr_wr_en), .spsr_wr_data(spsr_wr_data), .spsr_rd_data(spsr_rd_data)
   );

   // reference state, laid out from the requirements
   logic [31:0] m_lo [8];
   logic [31:0] m_hi [2][5];    // [0] user copy, [1] fast-interrupt copy
   logic [31:0] m_sl [6][2];    // R13/R14 per bank
   logic [31:0] m_st [5];       // saved status per exception bank

   logic [4:0] modes [8] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                             5'b10111, 5'b11011, 5'b11111, 5'b00000};

   function automatic int mbank(input logic [4:0] m);
      case (m)
         5'b10001: return 1;
         5'b10010: return 2;
         5'b10011: return 3;
         5'b10111: return 4;
         5'b11011: return 5;
         default:  return 0;
      endcase
   endfunction

   function automatic logic [31:0] exp_rd(input logic [4:0] m, input int r);
      int b;
      b = mbank(m);
      if (r == 15)     return pc_value;
      else if (r < 8)  return m_lo[r];
      else if (r < 13) return m_hi[(b == 1) ? 1 : 0][r-8];
      else             return m_sl[b][r-13];
   endfunction

   function automatic logic [31:0] exp_st(input logic [4:0] m);
      int b;
      b = mbank(m);
      return (b == 0) ? 32'h0 : m_st[b-1];
   endfunction

   function automatic string tag_for(input int mi, input int r);
      if (r == 15)     return "R6";
      else if (mi == 7) return "R5";
      else if (r < 8)  return "R2";
      else if (r < 13) return "R3";
      else             return "R4";
   endfunction

   task automatic model_wr(input logic [4:0] m, input int r, input logic [31:0] d);
      int b;
      b = mbank(m);
      if (r == 15)     ;
      else if (r < 8)  m_lo[r] = d;
      else if (r < 13) m_hi[(b == 1) ? 1 : 0][r-8] = d;
      else             m_sl[b][r-13] = d;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_write(input logic [4:0] m, input int r, input logic [31:0] d);
      @(negedge clk);
      mode = m; wr_idx = 4'(r); wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      model_wr(m, r, d);
   endtask

   task automatic sweep_reads(input string forced);
      for (int mi = 0; mi < 8; mi++) begin
         for (int r = 0; r < 16; r++) begin
            @(negedge clk);
            mode = modes[mi]; rd_a_idx = 4'(r); rd_b_idx = 4'(15 - r);
            #2;
            chk((forced != "") ? forced : tag_for(mi, r), rd_a_data, exp_rd(modes[mi], r));
            chk((forced != "") ? forced : "R8", rd_b_data, exp_rd(modes[mi], 15 - r));
         end
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
   end

   initial begin
      logic [31:0] oldv;
      rst_n = 1'b0; mode = 5'b10000; rd_a_idx = 0; rd_b_idx = 0;
      wr_en = 0; wr_idx = 0; wr_data = 0; pc_value = 32'hC0DE_0100;
      lr_ovr_en = 0; lr_ovr_mode = 5'b10000; lr_ovr_data = 0;
      spsr_wr_en = 0; spsr_wr_data = 0;
      for (int i = 0; i < 8; i++) m_lo[i] = 0;
      for (int i = 0; i < 2; i++) for (int j = 0; j < 5; j++) m_hi[i][j] = 0;
      for (int i = 0; i < 6; i++) for (int j = 0; j < 2; j++) m_sl[i][j] = 0;
      for (int i = 0; i < 5; i++) m_st[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state of every view and status slot
      sweep_reads("R1");
      for (int mi = 0; mi < 7; mi++) begin
         @(negedge clk); mode = modes[mi]; #2;
         chk("R1", spsr_rd_data, 32'h0);
      end

      // distinct value into every (mode, register) pair, R15 writes included
      for (int mi = 0; mi < 8; mi++)
         for (int r = 0; r < 16; r++)
            do_write(modes[mi], r, {8'hA0 + 8'(mi), 8'(r), 16'h1000 + 16'(mi * 16 + r)});
      sweep_reads("");

      // R6: R15 follows the supplied counter on both ports
      @(negedge clk); pc_value = 32'h0000_BEEF; rd_a_idx = 15; rd_b_idx = 15; mode = 5'b10001; #2;
      chk("R6", rd_a_data, 32'h0000_BEEF);
      chk("R6", rd_b_data, 32'h0000_BEEF);

      // R7: read during write returns the old value, new one next cycle
      @(negedge clk);
      mode = 5'b10000; rd_a_idx = 3; wr_idx = 3; wr_data = 32'h7777_0003; wr_en = 1'b1;
      #2;
      oldv = exp_rd(5'b10000, 3);
      chk("R7", rd_a_data, oldv);
      @(negedge clk); wr_en = 1'b0; model_wr(5'b10000, 3, 32'h7777_0003); #2;
      chk("R7", rd_a_data, 32'h7777_0003);

      // R9: override into a mode that is not current
      @(negedge clk);
      mode = 5'b10011; rd_b_idx = 14;
      lr_ovr_en = 1'b1; lr_ovr_mode = 5'b10010; lr_ovr_data = 32'h9999_0012;
      @(negedge clk); lr_ovr_en = 1'b0; m_sl[2][1] = 32'h9999_0012; #2;
      chk("R9", rd_b_data, exp_rd(5'b10011, 14));
      @(negedge clk); mode = 5'b10010; #2;
      chk("R9", rd_b_data, 32'h9999_0012);

      // R9: same-cycle collision, override targets system (shares user copy)
      @(negedge clk);
      mode = 5'b10000; rd_b_idx = 14; wr_idx = 14; wr_data = 32'h1111_2222; wr_en = 1'b1;
      lr_ovr_en = 1'b1; lr_ovr_mode = 5'b11111; lr_ovr_data = 32'h3333_4444;
      @(negedge clk); wr_en = 1'b0; lr_ovr_en = 1'b0;
      model_wr(5'b10000, 14, 32'h1111_2222); m_sl[0][1] = 32'h3333_4444; #2;
      chk("R9", rd_b_data, 32'h3333_4444);
      @(negedge clk); mode = 5'b11111; #2;
      chk("R9", rd_b_data, 32'h3333_4444);

      // R10 / R11: saved status per mode
      for (int mi = 0; mi < 8; mi++) begin
         @(negedge clk);
         mode = modes[mi]; spsr_wr_en = 1'b1; spsr_wr_data = 32'h5000_0000 + 32'(mi);
         @(negedge clk); spsr_wr_en = 1'b0;
         if (mbank(modes[mi]) != 0) m_st[mbank(modes[mi]) - 1] = 32'h5000_0000 + 32'(mi);
      end
      for (int mi = 0; mi < 8; mi++) begin
         @(negedge clk); mode = modes[mi]; #2;
         chk((mbank(modes[mi]) == 0) ? "R11" : "R10", spsr_rd_data, exp_st(modes[mi]));
      end

      // final sweep confirms nothing else moved
      sweep_reads("");
      finish_run();
   end
endmodule